// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim/Complete

This block gathers level-sensitive interrupt requests from a numbered set of sources and presents them to a small number of processor contexts. Each source carries a small priority value. Each context has its own enable bit per source and its own priority threshold, and drives one interrupt line. A context reads its claim register to take the most urgent source it may serve. When software has finished with that source, it writes the source number back to the same register.

Each source passes through a gateway. The gateway latches a level request as pending. Once a context claims the source, the gateway holds it in service and accepts no new request until the completion is written. Registers sit on a simple synchronous 32-bit bus. A read returns its data on the cycle after the request.

Top module: `irq_router`

## Requirements
- R1: Source number 0 does not exist. Its priority register and enable bits always read 0, writes to them have no effect, and it never becomes pending.
- R2: The priority of source n is at byte offset 4*n. Only the low 3 bits are stored, and the upper bits read 0.
- R3: The enable vector of context c begins at offset 0x2080 + 0x100*c. Source n is controlled by bit n%32 of the word at +4*(n/32). Bits for sources that do not exist read 0.
- R4: A context's threshold register is at 0x201000 + 0x2000*c. A pending, enabled source is eligible only when its priority is strictly above the threshold. Threshold 7 therefore masks every source, and priority 0 never interrupts.
- R5: Reading the claim register at threshold offset +4 returns the number of the highest-priority eligible source and moves that source from pending to in service. It returns 0 when nothing is eligible.
- R6: When eligible sources tie on priority, the lowest-numbered one is claimed first.
- R7: Writing a source number to the claim register completes that source. If its request is still asserted, it becomes pending again on the following cycle.
- R8: A completion write has no effect when the source is not enabled for the writing context or is not in service.
- R9: A request is latched as pending only while the source is neither pending nor in service. A pending source stays pending after its request input drops.
- R10: Each context's interrupt output is registered. It rises one cycle after a source becomes eligible and falls one cycle after the last eligible source is claimed. It is 0 out of reset.
- R11: Reads from unmapped or unaligned offsets return 0, and writes to them change nothing.
- R12: Pending state is shared between contexts. A source claimed by one context is no longer eligible in any other context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access request this cycle |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| srcIrq | input | NUM_SRC | Level request per source (bit 0 unused) |
| ctxIrq | output | NUM_CTX | Interrupt line per context |

## Verification
The bench builds the router with 40 sources and 2 contexts. With 40 sources the enable vector spans two words, so the second word's bit placement and its read-as-zero bits for missing sources (sources 40 to 63) can be checked. The two contexts exercise the shared pending state, completions written from a context that does not enable the source, and independent thresholds.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_PRIO,
    K_EN,
    K_THR,
    K_CLAIM
  } regKind_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    regKind_e kind;
    logic     wr;
    logic     rd;
  } strobe_t;

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int ADDR_W  = 26
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           st,
  output logic [(NUM_CTX > 1 ? $clog2(NUM_CTX) : 1)-1:0] ctxSel,
  output logic [$clog2(NUM_SRC)-1:0]                    idxSel
);
  localparam int CW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int SW = $clog2(NUM_SRC);
  localparam int NW = (NUM_SRC + 31) / 32;
  localparam logic [ADDR_W-1:0] PRIO_END = ADDR_W'(4 * NUM_SRC);
  localparam logic [ADDR_W-1:0] EN_BASE  = ADDR_W'(32'h2080);
  localparam logic [ADDR_W-1:0] EN_END   = ADDR_W'(32'h2080 + NUM_CTX * 32'h100);
  localparam logic [ADDR_W-1:0] CX_BASE  = ADDR_W'(32'h201000);
  localparam logic [ADDR_W-1:0] CX_END   = ADDR_W'(32'h201000 + NUM_CTX * 32'h2000);

  logic [ADDR_W-1:0] enOff, cxOff;

  assign enOff = busAddr - EN_BASE;
  assign cxOff = busAddr - CX_BASE;

  always_comb begin
    st.kind = K_NONE;
    st.wr   = busSel & busWr;
    st.rd   = busSel & ~busWr;
    ctxSel  = '0;
    idxSel  = '0;
    if (busSel && busAddr[1:0] == 2'b00) begin
      if (busAddr < PRIO_END) begin
        st.kind = K_PRIO;
        idxSel  = SW'(busAddr >> 2);
      end else if (busAddr >= EN_BASE && busAddr < EN_END) begin
        if (32'(enOff[7:2]) < NW) begin
          st.kind = K_EN;
          ctxSel  = CW'(enOff >> 8);
          idxSel  = SW'(enOff[7:2]);
        end
      end else if (busAddr >= CX_BASE && busAddr < CX_END) begin
        ctxSel = CW'(cxOff >> 13);
        if (cxOff[12:0] == 13'h0)      st.kind = K_THR;
        else if (cxOff[12:0] == 13'h4) st.kind = K_CLAIM;
      end
    end
  end

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             st,
  input  logic [(NUM_CTX > 1 ? $clog2(NUM_CTX) : 1)-1:0] ctxSel,
  input  logic [$clog2(NUM_SRC)-1:0]                    idxSel,
  input  logic [31:0]         wdata,
  input  logic [NUM_SRC-1:0]  srcIn,
  output logic [31:0]         rdata,
  output logic [NUM_CTX-1:0]  irqOut
);
  localparam int SW = $clog2(NUM_SRC);
  localparam logic [PRIO_W-1:0] MAXP = '1;

  logic [PRIO_W-1:0]  prio    [NUM_SRC];
  logic [NUM_SRC-1:0] en      [NUM_CTX];
  logic [PRIO_W-1:0]  thr     [NUM_CTX];
  logic [NUM_SRC-1:0] pending, inServ, nextPend, nextServ;
  logic [SW-1:0]      bestId  [NUM_CTX];
  logic [PRIO_W-1:0]  bestPri [NUM_CTX];
  logic [NUM_CTX-1:0] anyEl;
  logic [31:0]        enWord;
  logic               claimRd, doneWr, doneOk;
  logic [SW-1:0]      claimIdx, doneIdx;

  // per-context arbitration: strictly above threshold, ties to lowest id
  always_comb begin
    for (int c = 0; c < NUM_CTX; c++) begin
      bestId[c]  = '0;
      bestPri[c] = '0;
      for (int s = 1; s < NUM_SRC; s++) begin
        if (pending[s] && en[c][s] && prio[s] > thr[c] && prio[s] > bestPri[c]) begin
          bestId[c]  = SW'(s);
          bestPri[c] = prio[s];
        end
      end
      anyEl[c] = (bestId[c] != '0);
    end
  end

  assign claimRd  = st.rd && st.kind == K_CLAIM;
  assign claimIdx = bestId[ctxSel];
  assign doneWr   = st.wr && st.kind == K_CLAIM;
  assign doneIdx  = wdata[SW-1:0];
  assign doneOk   = doneWr && wdata < 32'(NUM_SRC) && wdata != 32'd0 &&
                    en[ctxSel][doneIdx] && inServ[doneIdx];

  // gateways
  always_comb begin
    nextPend    = pending | (srcIn & ~pending & ~inServ);
    nextPend[0] = 1'b0;
    nextServ    = inServ;
    if (claimRd && claimIdx != '0) begin
      nextPend[claimIdx] = 1'b0;
      nextServ[claimIdx] = 1'b1;
    end
    if (doneOk) nextServ[doneIdx] = 1'b0;
  end

  always_comb begin
    enWord = '0;
    for (int b = 0; b < 32; b++) begin
      if (32'(idxSel) * 32 + b < NUM_SRC)
        enWord[b] = en[ctxSel][SW'(32'(idxSel) * 32 + b)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SRC; s++) prio[s] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
      pending <= '0;
      inServ  <= '0;
      rdata   <= '0;
      irqOut  <= '0;
    end else begin
      pending <= nextPend;
      inServ  <= nextServ;
      irqOut  <= anyEl;
      if (st.wr) begin
        case (st.kind)
          K_PRIO: if (idxSel != '0) prio[idxSel] <= wdata[PRIO_W-1:0];
          K_THR:  thr[ctxSel] <= wdata[PRIO_W-1:0];
          K_EN: begin
            for (int b = 0; b < 32; b++) begin
              if (32'(idxSel) * 32 + b < NUM_SRC && 32'(idxSel) * 32 + b != 0)
                en[ctxSel][SW'(32'(idxSel) * 32 + b)] <= wdata[b];
            end
          end
          default: ;
        endcase
      end
      if (st.rd) begin
        case (st.kind)
          K_PRIO:  rdata <= 32'(prio[idxSel]);
          K_EN:    rdata <= enWord;
          K_THR:   rdata <= 32'(thr[ctxSel]);
          K_CLAIM: rdata <= 32'(claimIdx);
          default: rdata <= '0;
        endcase
      end
    end
  end

  // R1
  src0_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pending[0] && !inServ[0]);

  // R9
  gate_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending & inServ) == '0);

  // R5
  claim_serv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (claimRd && claimIdx != '0) |=> inServ[$past(claimIdx)]);

  generate
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctxChk
      // R4
      thr_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($past(thr[c]) == MAXP) |-> !irqOut[c]);
    end
    for (genvar s = 1; s < NUM_SRC; s++) begin : g_srcChk
      // R8
      done_only_chk: assert property (@(posedge clk) disable iff (!rstN)
        $fell(inServ[s]) |-> $past(doneWr && wdata == 32'(s)));
    end
  endgenerate

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 26
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] srcIrq,
  output logic [NUM_CTX-1:0] ctxIrq
);
  localparam int CW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int SW = $clog2(NUM_SRC);

  strobe_t       st;
  logic [CW-1:0] ctxSel;
  logic [SW-1:0] idxSel;

  irq_router_ctrl #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .st(st), .ctxSel(ctxSel), .idxSel(idxSel)
  );

  irq_router_dp #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .ctxSel(ctxSel), .idxSel(idxSel),
    .wdata(busWdata), .srcIn(srcIrq), .rdata(busRdata), .irqOut(ctxIrq)
  );

endmodule

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
  localparam int NS = 40;
  localparam int NC = 2;
  localparam int AW = 26;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [NS-1:0] srcIrq = '0;
  logic [NC-1:0] ctxIrq;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  irq_router #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(3), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcIrq(srcIrq), .ctxIrq(ctxIrq)
  );

  function automatic logic [AW-1:0] aPrio(int s); return AW'(4 * s); endfunction
  function automatic logic [AW-1:0] aEn(int c, int w); return AW'(32'h2080 + c * 32'h100 + 4 * w); endfunction
  function automatic logic [AW-1:0] aThr(int c); return AW'(32'h201000 + c * 32'h2000); endfunction
  function automatic logic [AW-1:0] aClm(int c); return AW'(32'h201004 + c * 32'h2000); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(posedge clk); #1;
    d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setSrc(input int s, input logic v);
    @(negedge clk);
    srcIrq[s] = v;
  endtask

  task automatic tReset();
    logic [31:0] d;
    chk("R10 reset irq", 32'(ctxIrq), 32'd0);
    rd(aPrio(3), d);  chk("R2 reset prio", d, 0);
    rd(aThr(1), d);   chk("R4 reset thr", d, 0);
    rd(aClm(0), d);   chk("R5 empty claim", d, 0);
  endtask

  task automatic tRegs();
    logic [31:0] d;
    wr(aPrio(0), 32'h5); rd(aPrio(0), d); chk("R1 prio0", d, 0);
    wr(aPrio(3), 32'hFF); rd(aPrio(3), d); chk("R2 prio width", d, 32'h7);
    wr(aEn(0, 0), 32'hFFFF_FFFF); rd(aEn(0, 0), d); chk("R1 en bit0", d, 32'hFFFF_FFFE);
    rd(aEn(1, 0), d); chk("R3 ctx1 untouched", d, 0);
    wr(aEn(1, 1), 32'hFFFF_FFFF); rd(aEn(1, 1), d); chk("R3 word1 range", d, 32'hFF);
    wr(aEn(0, 0), 0); wr(aEn(1, 1), 0);
    wr(aThr(1), 32'h3);
    wr(AW'(32'h1000), 32'h1234); rd(AW'(32'h1000), d); chk("R11 unmapped rd", d, 0);
    wr(aThr(1) + AW'(8), 32'h6); rd(aThr(1), d); chk("R11 unmapped wr", d, 32'h3);
    rd(aPrio(3) + AW'(1), d); chk("R11 unaligned", d, 0);
    wr(aThr(1), 0); wr(aPrio(3), 0);
  endtask

  task automatic tClaim();
    logic [31:0] d;
    wr(aPrio(5), 2); wr(aPrio(9), 6); wr(aPrio(12), 6);
    wr(aEn(0, 0), (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 12));
    @(negedge clk);
    srcIrq[5] = 1'b1; srcIrq[9] = 1'b1; srcIrq[12] = 1'b1;
    cyc(1); chk("R10 irq latency", 32'(ctxIrq[0]), 0);
    cyc(1); chk("R10 irq rise", 32'(ctxIrq[0]), 1);
    rd(aClm(0), d); chk("R6 tie lowest", d, 9);
    rd(aClm(0), d); chk("R5 next prio", d, 12);
    rd(aClm(0), d); chk("R5 low prio", d, 5);
    cyc(1); chk("R10 irq fall", 32'(ctxIrq[0]), 0);
    rd(aClm(0), d); chk("R5 none left", d, 0);
    @(negedge clk);
    srcIrq[5] = 1'b0; srcIrq[9] = 1'b0; srcIrq[12] = 1'b0;
    wr(aClm(0), 9); wr(aClm(0), 12); wr(aClm(0), 5);
    cyc(2); chk("R7 no repend when low", 32'(ctxIrq[0]), 0);
  endtask

  task automatic tThresh();
    logic [31:0] d;
    wr(aPrio(7), 3); wr(aEn(0, 0), 32'h1 << 7); wr(aThr(0), 3);
    setSrc(7, 1'b1);
    cyc(3); chk("R4 equal masked", 32'(ctxIrq[0]), 0);
    rd(aClm(0), d); chk("R4 claim masked", d, 0);
    wr(aThr(0), 2); cyc(2); chk("R4 above thr", 32'(ctxIrq[0]), 1);
    wr(aPrio(7), 7); wr(aThr(0), 7); cyc(2); chk("R4 thr max", 32'(ctxIrq[0]), 0);
    wr(aThr(0), 0); wr(aPrio(7), 0); cyc(2); chk("R4 prio zero", 32'(ctxIrq[0]), 0);
    wr(aPrio(7), 1); cyc(2); chk("R4 thr zero", 32'(ctxIrq[0]), 1);
    rd(aClm(0), d); chk("R5 claim 7", d, 7);
    wr(aClm(0), 7);
    cyc(2); chk("R7 repend", 32'(ctxIrq[0]), 1);
    rd(aClm(0), d); chk("R7 reclaim", d, 7);
    setSrc(7, 1'b0); wr(aClm(0), 7);
  endtask

  task automatic tComplete();
    logic [31:0] d;
    wr(aPrio(20), 4); wr(aPrio(25), 4); wr(aEn(0, 0), (32'h1 << 20) | (32'h1 << 25));
    setSrc(20, 1'b1); cyc(2);
    rd(aClm(0), d); chk("R5 claim 20", d, 20);
    setSrc(20, 1'b0); setSrc(20, 1'b1); cyc(2);
    rd(aClm(0), d); chk("R9 blocked in service", d, 0);
    wr(aClm(1), 20); cyc(2);
    rd(aClm(0), d); chk("R8 foreign complete", d, 0);
    wr(aClm(0), 20); cyc(2);
    rd(aClm(0), d); chk("R7 complete frees", d, 20);
    setSrc(20, 1'b0); wr(aClm(0), 20);
    wr(aClm(0), 20); cyc(2);
    chk("R8 double complete", 32'(ctxIrq[0]), 0);
    setSrc(25, 1'b1); setSrc(25, 1'b0); cyc(2);
    rd(aClm(0), d); chk("R9 latched level", d, 25);
    wr(aClm(0), 25);
  endtask

  task automatic tCtx();
    logic [31:0] d;
    wr(aPrio(30), 2); wr(aEn(0, 0), 32'h1 << 30); wr(aEn(1, 0), 32'h1 << 30);
    setSrc(30, 1'b1); cyc(2);
    chk("R12 both irq", 32'(ctxIrq), 32'h3);
    rd(aClm(1), d); chk("R12 ctx1 claim", d, 30);
    cyc(1); chk("R12 both drop", 32'(ctxIrq), 0);
    rd(aClm(0), d); chk("R12 ctx0 empty", d, 0);
    setSrc(30, 1'b0); wr(aClm(1), 30);
    wr(aPrio(35), 5); wr(aEn(1, 1), 32'h1 << 3);
    setSrc(35, 1'b1); cyc(2);
    chk("R3 ctx0 not enabled", 32'(ctxIrq[0]), 0);
    rd(aClm(1), d); chk("R3 word1 bit3", d, 35);
    setSrc(35, 1'b0); wr(aClm(1), 35);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3);
    @(negedge clk) rstN = 1'b1;
    cyc(1);
    tReset();
    tRegs();
    tClaim();
    tThresh();
    tComplete();
    tCtx();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule